// File: doc/BRIEF.md
# Three-Modulus Residue-to-Integer Reconstruction Engine

This block rebuilds an integer from its remainders with respect to three fixed, pairwise coprime moduli (229, 233 and 239 by default). For each residue triple it returns the one integer in the range 0 to N-1 that has those remainders, where N = 229 × 233 × 239 = 12752323. A typical use is recovering an unknown tone frequency from the aliased frequencies measured by three slow samplers whose rates are set by these moduli. The block only does the reconstruction. Producing the residues happens upstream.

The engine is iterative. At elaboration time it derives one reconstruction weight per modulus and builds an eight-entry table holding every subset sum of those weights. It then walks the residue bits from the most significant bit down. On each cycle it doubles the accumulator modulo N and adds the table entry chosen by the current bit of all three residues, again modulo N. A full result therefore takes exactly one cycle per residue bit, independent of the values.

Both data interfaces use valid/ready. A triple is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is high only while the engine is idle. The upstream side must hold its data until that edge. A result is offered with `out_valid` and stays frozen until a clock edge where `out_ready` is high. The error pulse is a plain status pin.

Top module: `crt_engine`

## Requirements
- R1: Every offered result is below N = 12752323 and fits the 24-bit `out_value` port.
- R2: Every offered result leaves remainder `rsd_a` modulo 229, `rsd_b` modulo 233 and `rsd_c` modulo 239, using the residues captured at acceptance.
- R3: The triple (a=171, b=34, c=49) reconstructs to 12000000.
- R4: A triple whose three residues all equal one value r with r < 229 reconstructs to r.
- R5: The triple (a=228, b=232, c=238) reconstructs to 12752322, the largest value in range.
- R6: An accepted triple with any residue at or above its modulus raises `err_o` for exactly the one cycle after the accepting edge, and produces no `out_valid`.
- R7: `in_ready` is low from acceptance until the result handshake completes. A different triple presented on `in_valid` during that time is not taken and does not change the result.
- R8: `out_valid` rises exactly 8 clock edges after the accepting edge (one edge per residue bit).
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_value` stays unchanged. After the edge where both are high, `out_valid` is low and `in_ready` is high.
- R10: During and right after reset, `in_ready` is 1, `out_valid` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Residue triple offered |
| in_ready | output | 1 | Engine idle and able to accept |
| rsd_a | input | 8 | Residue for modulus 229 |
| rsd_b | input | 8 | Residue for modulus 233 |
| rsd_c | input | 8 | Residue for modulus 239 |
| out_valid | output | 1 | Reconstructed value offered |
| out_ready | input | 1 | Downstream takes the value |
| out_value | output | 24 | Reconstructed integer |
| err_o | output | 1 | One-cycle pulse: out-of-range residue rejected |

## Verification
The bound checker covers the properties that hold on every cycle. It checks that each offered value is below N and agrees with all three captured residues. It also checks the fixed 8-edge latency, a stalled result staying frozen, the idle state right after a handshake, and that the error pulse follows only a rejected triple and is never paired with a result. The bench scenarios cover what the checker cannot. These are the specific worked values (the largest value in range, the 12000000 case and the equal-residue cases), a second triple held on the input during a busy period leaving the result untouched, and recovery to normal operation after a rejected triple.

// File: rtl/crt_pkg.sv
package crt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } crt_state_e;

  // Multiplicative inverse of a modulo m, found by search at elaboration time.
  function automatic longint inv_mod(input longint a, input longint m);
    longint found;
    found = 0;
    for (longint i = 1; i < m; i++) begin
      if (found == 0 && ((a * i) % m) == 1) found = i;
    end
    return found;
  endfunction

  // Weight for one modulus: product of the other two times its inverse
  // modulo this modulus, reduced modulo the full product.
  function automatic longint crt_weight(input longint m_self,
                                        input longint m_x,
                                        input longint m_y);
    longint others;
    longint full;
    others = m_x * m_y;
    full   = others * m_self;
    return (others * inv_mod(others % m_self, m_self)) % full;
  endfunction

endpackage

// File: rtl/crt_lane_check.sv
module crt_lane_check #(
  parameter int RW  = 8,
  parameter int MOD = 229
) (
  input  logic [RW-1:0] rsd,
  output logic          ok
);
  assign ok = (32'(rsd) < 32'(MOD));
endmodule

// File: rtl/crt_weight_table.sv
module crt_weight_table #(
  parameter int MOD_A = 229,
  parameter int MOD_B = 233,
  parameter int MOD_C = 239,
  parameter int OW    = 24
) (
  input  logic [2:0]    sel,
  output logic [OW-1:0] weight
);
  localparam longint PROD = longint'(MOD_A) * longint'(MOD_B) * longint'(MOD_C);
  localparam longint WA = crt_pkg::crt_weight(MOD_A, MOD_B, MOD_C);
  localparam longint WB = crt_pkg::crt_weight(MOD_B, MOD_A, MOD_C);
  localparam longint WC = crt_pkg::crt_weight(MOD_C, MOD_A, MOD_B);

  logic [OW-1:0] tbl [8];

  for (genvar k = 0; k < 8; k++) begin : g_ent
    localparam longint SUM = (((k & 1) != 0) ? WA : 64'd0)
                           + (((k & 2) != 0) ? WB : 64'd0)
                           + (((k & 4) != 0) ? WC : 64'd0);
    assign tbl[k] = OW'(SUM % PROD);
  end

  assign weight = tbl[sel];
endmodule

// File: rtl/crt_mod_step.sv
module crt_mod_step #(
  parameter int     OW   = 24,
  parameter longint NMOD = 12752323
) (
  input  logic [OW-1:0] acc,
  input  logic [OW-1:0] addend,
  output logic [OW-1:0] nxt
);
  localparam logic [OW:0] LIM = (OW+1)'(NMOD);

  logic [OW:0] dbl;
  logic [OW:0] dbl_r;
  logic [OW:0] sum;

  always_comb begin
    dbl   = {acc, 1'b0};
    dbl_r = (dbl >= LIM) ? (dbl - LIM) : dbl;
    sum   = dbl_r + {1'b0, addend};
    nxt   = (sum >= LIM) ? OW'(sum - LIM) : OW'(sum);
  end
endmodule

// File: rtl/crt_engine.sv
module crt_engine #(
  parameter int MOD_A = 229,
  parameter int MOD_B = 233,
  parameter int MOD_C = 239,
  parameter int RW    = 8,
  localparam longint NMOD = longint'(MOD_A) * longint'(MOD_B) * longint'(MOD_C),
  localparam int     OW   = $clog2(NMOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [RW-1:0] rsd_a,
  input  logic [RW-1:0] rsd_b,
  input  logic [RW-1:0] rsd_c,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_value,
  output logic          err_o
);
  import crt_pkg::*;

  localparam int IW = (RW > 1) ? $clog2(RW) : 1;
  localparam int MODS [3] = '{MOD_A, MOD_B, MOD_C};

  crt_state_e    st;
  logic [RW-1:0] lane_in [3];
  logic [RW-1:0] cap     [3];
  logic [2:0]    lane_ok;
  logic [IW-1:0] bit_idx;
  logic [2:0]    sel;
  logic [OW-1:0] acc;
  logic [OW-1:0] acc_nxt;
  logic [OW-1:0] wsel;

  assign lane_in[0] = rsd_a;
  assign lane_in[1] = rsd_b;
  assign lane_in[2] = rsd_c;

  for (genvar g = 0; g < 3; g++) begin : g_lane
    crt_lane_check #(.RW(RW), .MOD(MODS[g])) u_lane (
      .rsd (lane_in[g]),
      .ok  (lane_ok[g])
    );
    assign sel[g] = cap[g][bit_idx];
  end

  crt_weight_table #(.MOD_A(MOD_A), .MOD_B(MOD_B), .MOD_C(MOD_C), .OW(OW)) u_tbl (
    .sel    (sel),
    .weight (wsel)
  );

  crt_mod_step #(.OW(OW), .NMOD(NMOD)) u_step (
    .acc    (acc),
    .addend (wsel),
    .nxt    (acc_nxt)
  );

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_HOLD);
  assign out_value = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      acc     <= '0;
      bit_idx <= '0;
      err_o   <= 1'b0;
      cap     <= '{default: '0};
    end else begin
      err_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (in_valid) begin
            if (&lane_ok) begin
              cap     <= lane_in;
              acc     <= '0;
              bit_idx <= IW'(RW - 1);
              st      <= ST_RUN;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          acc <= acc_nxt;
          if (bit_idx == '0) st <= ST_HOLD;
          else               bit_idx <= bit_idx - 1'b1;
        end
        ST_HOLD: begin
          if (out_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crt_engine_chk.sv
module crt_engine_chk #(
  parameter int MOD_A = 229,
  parameter int MOD_B = 233,
  parameter int MOD_C = 239,
  parameter int RW    = 8,
  localparam longint NMOD = longint'(MOD_A) * longint'(MOD_B) * longint'(MOD_C),
  localparam int     OW   = $clog2(NMOD)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [RW-1:0] rsd_a,
  input logic [RW-1:0] rsd_b,
  input logic [RW-1:0] rsd_c,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_value,
  input logic          err_o
);
  logic [31:0]   val32;
  logic          bad_in;
  logic          take;
  logic [RW-1:0] ca, cb, cc;
  logic          run;
  logic [31:0]   lat;

  assign val32  = 32'(out_value);
  assign bad_in = (32'(rsd_a) >= 32'(MOD_A)) || (32'(rsd_b) >= 32'(MOD_B)) ||
                  (32'(rsd_c) >= 32'(MOD_C));
  assign take   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca <= '0; cb <= '0; cc <= '0;
      run <= 1'b0;
      lat <= '0;
    end else if (take && !bad_in) begin
      ca <= rsd_a; cb <= rsd_b; cc <= rsd_c;
      run <= 1'b1;
      lat <= '0;
    end else if (run) begin
      lat <= lat + 1;
      if (out_valid) run <= 1'b0;
    end
  end

  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (val32 < 32'(NMOD))); // R1
  AST_CONGRUENT_A: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((val32 % 32'(MOD_A)) == 32'(ca))); // R2
  AST_CONGRUENT_B: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((val32 % 32'(MOD_B)) == 32'(cb))); // R2
  AST_CONGRUENT_C: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((val32 % 32'(MOD_C)) == 32'(cc))); // R2
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bad_in) |=> (err_o && !out_valid)); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(take && bad_in)); // R6
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat == 32'(RW))); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value))); // R9
  AST_HANDSHAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R9
endmodule

bind crt_engine crt_engine_chk #(
  .MOD_A(MOD_A), .MOD_B(MOD_B), .MOD_C(MOD_C), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rsd_a(rsd_a), .rsd_b(rsd_b), .rsd_c(rsd_c), .out_valid(out_valid),
  .out_ready(out_ready), .out_value(out_value), .err_o(err_o)
);

// File: tb/crt_engine_tb.sv
module crt_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  rsd_a = '0, rsd_b = '0, rsd_c = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_value;
  logic        err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  crt_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rsd_a(rsd_a), .rsd_b(rsd_b), .rsd_c(rsd_c), .out_valid(out_valid),
    .out_ready(out_ready), .out_value(out_value), .err_o(err_o)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  c;
    logic        known;
    logic [23:0] exp;
    logic [3:0]  stall;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd171, 8'd34,  8'd49,  1'b1, 24'd12000000, 4'd0}, // R3
    '{8'd228, 8'd232, 8'd238, 1'b1, 24'd12752322, 4'd3}, // R5
    '{8'd0,   8'd0,   8'd0,   1'b1, 24'd0,        4'd0}, // R4
    '{8'd1,   8'd1,   8'd1,   1'b1, 24'd1,        4'd1}, // R4
    '{8'd100, 8'd100, 8'd100, 1'b1, 24'd100,      4'd0}, // R4
    '{8'd228, 8'd228, 8'd228, 1'b1, 24'd228,      4'd2}, // R4
    '{8'd1,   8'd0,   8'd0,   1'b0, 24'd0,        4'd0}, // R2
    '{8'd0,   8'd1,   8'd0,   1'b0, 24'd0,        4'd0}, // R2
    '{8'd0,   8'd0,   8'd1,   1'b0, 24'd0,        4'd4}, // R2
    '{8'd200, 8'd17,  8'd238, 1'b0, 24'd0,        4'd0}, // R2
    '{8'd5,   8'd231, 8'd0,   1'b0, 24'd0,        4'd1}, // R2
    '{8'd255, 8'd255, 8'd255, 1'b0, 24'd0,        4'd0}  // replaced below
  };

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Runs one triple; intrude presents a second triple while busy (R7).
  task automatic run_triple(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                            input bit known, input longint expv, input int stall,
                            input bit intrude);
    int k;
    longint got;
    @(negedge clk);
    check(in_ready == 1'b1, "R7 idle before send", in_ready, 1);
    in_valid = 1'b1; rsd_a = a; rsd_b = b; rsd_c = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    k = 1;
    if (intrude) begin
      @(negedge clk); k++;
      check(in_ready == 1'b0, "R7 busy not ready", in_ready, 0);
      in_valid = 1'b1; rsd_a = 8'd7; rsd_b = 8'd9; rsd_c = 8'd11;
    end
    while (!out_valid && k < 40) begin
      @(negedge clk); k++;
    end
    k = k - 1;
    in_valid = 1'b0;
    check(k == 8, "R8 latency", k, 8);
    got = longint'(out_value);
    check(got < 12752323, "R1 range", got, 12752322);
    check(got % 229 == longint'(a) && got % 233 == longint'(b) && got % 239 == longint'(c),
          "R2 congruence", got, a);
    if (known) check(got == expv, "R3/R4/R5 value", got, expv);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(out_valid && longint'(out_value) == got, "R9 stall hold", out_value, got);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R9 after handshake", {out_valid, in_ready}, 1);
  endtask

  task automatic run_bad(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    bit seen_valid;
    bit extra_err;
    @(negedge clk);
    in_valid = 1'b1; rsd_a = a; rsd_b = b; rsd_c = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(err_o == 1'b1, "R6 error pulse", err_o, 1);
    seen_valid = out_valid;
    extra_err = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (out_valid) seen_valid = 1;
      if (err_o) extra_err = 1;
    end
    check(!seen_valid, "R6 no result", seen_valid, 0);
    check(!extra_err, "R6 single-cycle pulse", extra_err, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && err_o == 1'b0,
          "R10 in reset", {in_ready, out_valid, err_o}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && err_o == 1'b0,
          "R10 after reset", {in_ready, out_valid, err_o}, 3'b100);

    for (int v = 0; v < NV - 1; v++) begin
      run_triple(VECS[v].a, VECS[v].b, VECS[v].c, VECS[v].known,
                 longint'(VECS[v].exp), int'(VECS[v].stall), 1'b0);
    end

    // R7: a second triple held during the busy window is ignored
    run_triple(8'd171, 8'd34, 8'd49, 1'b1, 12000000, 1, 1'b1);

    // R6: each lane at its modulus, and the all-ones word
    run_bad(8'd229, 8'd0, 8'd0);
    run_bad(8'd0, 8'd233, 8'd0);
    run_bad(8'd0, 8'd0, 8'd239);
    run_bad(8'd255, 8'd255, 8'd255);

    // Recovery after rejection, upper boundary of each lane (R2)
    run_triple(8'd228, 8'd232, 8'd238, 1'b1, 12752322, 0, 1'b0); // R5
    run_triple(8'd228, 8'd0, 8'd0, 1'b0, 0, 0, 1'b0);            // R2

    finish_run();
  end
endmodule